// File: doc/BRIEF.md
# Completion-Timeout Error Injection Register

This block gives software a way to fake a completion-timeout error on any of several ports, so that the downstream error logging and escalation path can be tested without a real timed-out request. Each port owns a small control register, reached through a simple configuration read/write port that carries a function number (the port index) and a byte offset. A read-only capability header word describes the structure to software.

When software writes the injection bit of a port's control register and that bit goes from 0 to 1, the block emits exactly one clock-wide pulse. The pulse is ORed with the port's real completion-timeout signal, so the logging logic sees an ordinary error. Keeping the bit at 1 does nothing further; software must write it back to 0 before the next injection. A disable bit in the same register blocks injection, and a second bit is a plain scratch bit.

Top module: `cto_inject_top`

## Requirements
- R1: A read at offset 0x1d4 returns 0x00A10003 for any function number (length 0xA in bits 31:20, revision 0x1 in bits 19:16, ID 0x0003 in bits 15:0), and writes to 0x1d4 change nothing.
- R2: A read at offset 0x1d8 returns the selected port's control value in bits 2:0 with bits 31:3 zero; the control value resets to 0, and written bits 31:3 are dropped.
- R3: A write at 0x1d8 that moves bit 2 from 0 to 1, with bit 0 of the written data clear, makes that port's error output high for exactly the one cycle following the write edge.
- R4: A write that leaves bit 2 at 1 gives no pulse; after bit 2 is written to 0, a later 0-to-1 write pulses again.
- R5: Bit 0 is the disable: when the written data has bit 0 set, a 0-to-1 change of bit 2 in that write gives no pulse, and bit 2 is still stored as 1.
- R6: Bit 1 is a read/write scratch bit that never causes a pulse.
- R7: The 2-bit function number selects one of 4 ports; a write changes and can pulse only the selected port.
- R8: Reads at any offset other than 0x1d4 and 0x1d8 return 0, and writes there change no register and give no pulse.
- R9: Each port's error output is the OR of its real completion-timeout input and its injection pulse, with the real input passing through in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgFunc | input | 2 | Function number, selects the port |
| cfgOffset | input | 12 | Configuration byte offset |
| cfgWrData | input | 32 | Write data |
| cfgRdData | output | 32 | Read data for the addressed offset and port |
| realCtoErr | input | 4 | Real completion-timeout error per port |
| ctoErrOut | output | 4 | Merged error per port to the logging logic |

## Verification
The hardest case is the write that repeats a 1 into the injection bit: a design that edge-detects on the write strobe alone would pulse again, so the stimulus writes the same value twice in consecutive cycles and also back-to-back across ports. Disable interactions are reached by setting bit 2 together with bit 0 in one write, then clearing bit 2 and re-setting it with bit 0 clear, which must pulse. Real error inputs are held high during injection cycles to show the merge does not mask either source.

// File: rtl/cto_inject_pkg.sv
package cto_inject_pkg;
  localparam int PORTS     = 4;
  localparam int FUNC_W    = $clog2(PORTS);
  localparam int OFF_W     = 12;
  localparam int DATA_W    = 32;
  localparam int CTL_W     = 3;
  localparam int BIT_DIS   = 0;
  localparam int BIT_SCR   = 1;
  localparam int BIT_INJ   = 2;

  localparam logic [OFF_W-1:0] OFF_HDR = 12'h1d4;
  localparam logic [OFF_W-1:0] OFF_CTL = 12'h1d8;

  localparam logic [11:0] HDR_LEN = 12'h00a;
  localparam logic [3:0]  HDR_REV = 4'h1;
  localparam logic [15:0] HDR_ID  = 16'h0003;
  localparam logic [DATA_W-1:0] HDR_WORD = {HDR_LEN, HDR_REV, HDR_ID};

  typedef struct packed {
    logic             wrCtl;
    logic [PORTS-1:0] portHit;
    logic             rdHdr;
    logic             rdCtl;
  } strobe_t;
endpackage

// File: rtl/cto_inject_ctl.sv
module cto_inject_ctl
  import cto_inject_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [FUNC_W-1:0] cfgFunc,
  input  logic [OFF_W-1:0]  cfgOffset,
  output strobe_t           strb
);
  logic hitCtl;
  logic hitHdr;

  assign hitCtl = (cfgOffset == OFF_CTL);
  assign hitHdr = (cfgOffset == OFF_HDR);

  always_comb begin
    strb = '0;
    strb.rdHdr = hitHdr;
    strb.rdCtl = hitCtl;
    strb.wrCtl = cfgWrEn && hitCtl;
    for (int p = 0; p < PORTS; p++) begin
      strb.portHit[p] = (cfgFunc == FUNC_W'(p));
    end
  end

  // R7: at most one port addressed
  a_r7_one_port: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.portHit));
  // R8: header and control decodes never overlap
  a_r8_decode_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.rdHdr && strb.rdCtl));
endmodule

// File: rtl/cto_inject_dp.sv
module cto_inject_dp
  import cto_inject_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] cfgWrData,
  input  logic [PORTS-1:0]  realCtoErr,
  output logic [PORTS-1:0]  ctoErrOut,
  output logic [DATA_W-1:0] cfgRdData
);
  logic [CTL_W-1:0] ctrlQ [PORTS];
  logic [PORTS-1:0] pulseQ;

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic wrHere;
    logic armEdge;

    assign wrHere  = strb.wrCtl && strb.portHit[p];
    assign armEdge = wrHere && cfgWrData[BIT_INJ] && !ctrlQ[p][BIT_INJ]
                     && !cfgWrData[BIT_DIS];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        ctrlQ[p]  <= '0;
        pulseQ[p] <= 1'b0;
      end else begin
        if (wrHere) ctrlQ[p] <= cfgWrData[CTL_W-1:0];
        pulseQ[p] <= armEdge;
      end
    end

    assign ctoErrOut[p] = realCtoErr[p] | pulseQ[p];

    // R3: injection pulse lasts one cycle
    a_r3_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
      pulseQ[p] |=> !pulseQ[p]);
    // R3: pulse only follows a control write to this port
    a_r3_after_write: assert property (@(posedge clk) disable iff (!rstN)
      pulseQ[p] |-> $past(strb.wrCtl && strb.portHit[p]));
    // R4: pulse only when bit 2 has just risen
    a_r4_edge_only: assert property (@(posedge clk) disable iff (!rstN)
      pulseQ[p] |-> (ctrlQ[p][BIT_INJ] && !$past(ctrlQ[p][BIT_INJ])));
    // R5: no pulse while disable is stored
    a_r5_disable: assert property (@(posedge clk) disable iff (!rstN)
      pulseQ[p] |-> !ctrlQ[p][BIT_DIS]);
  end

  always_comb begin
    cfgRdData = '0;
    for (int p = 0; p < PORTS; p++) begin
      if (strb.portHit[p] && strb.rdCtl)
        cfgRdData = DATA_W'(ctrlQ[p]);
    end
    if (strb.rdHdr) cfgRdData = HDR_WORD;
  end
endmodule

// File: rtl/cto_inject_top.sv
module cto_inject_top
  import cto_inject_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [FUNC_W-1:0] cfgFunc,
  input  logic [OFF_W-1:0]  cfgOffset,
  input  logic [DATA_W-1:0] cfgWrData,
  output logic [DATA_W-1:0] cfgRdData,
  input  logic [PORTS-1:0]  realCtoErr,
  output logic [PORTS-1:0]  ctoErrOut
);
  strobe_t strb;

  cto_inject_ctl uCtl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgFunc(cfgFunc),
    .cfgOffset(cfgOffset), .strb(strb)
  );

  cto_inject_dp uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgWrData(cfgWrData),
    .realCtoErr(realCtoErr), .ctoErrOut(ctoErrOut), .cfgRdData(cfgRdData)
  );

  // R9: a real error always reaches the output
  a_r9_real_pass: assert property (@(posedge clk) disable iff (!rstN)
    (realCtoErr & ~ctoErrOut) == '0);
endmodule

// File: tb/cto_inject_top_test.sv
`timescale 1ns/1ps
module cto_inject_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgFunc = '0;
  logic [11:0] cfgOffset = '0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic [3:0]  realCtoErr = '0;
  logic [3:0]  ctoErrOut;

  int checks = 0;
  int errors = 0;
  logic [2:0] model [4];
  logic [3:0] expQ [$];
  string      tagQ [$];
  bit         running = 1'b1;

  always #2.5 clk = ~clk;

  cto_inject_top uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgFunc(cfgFunc),
    .cfgOffset(cfgOffset), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .realCtoErr(realCtoErr), .ctoErrOut(ctoErrOut)
  );

  task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // one driven cycle; pushes the expected output for the following edge
  task automatic step(input bit we, input logic [1:0] f, input logic [11:0] off,
                      input logic [31:0] d, input logic [3:0] rl, input string req);
    logic [3:0] pulse;
    @(negedge clk);
    cfgWrEn = we; cfgFunc = f; cfgOffset = off; cfgWrData = d; realCtoErr = rl;
    pulse = '0;
    if (we && off == 12'h1d8) begin
      if (d[2] && !model[f][2] && !d[0]) pulse[f] = 1'b1;
      model[f] = d[2:0];
    end
    expQ.push_back(pulse | rl);
    tagQ.push_back(req);
  endtask

  task automatic readChk(input logic [1:0] f, input logic [11:0] off,
                         input logic [31:0] exp, input string req);
    @(negedge clk);
    cfgWrEn = 1'b0; cfgFunc = f; cfgOffset = off;
    #1 check32(req, cfgRdData, exp);
  endtask

  // monitor: compares merged outputs just after each edge
  initial begin
    while (running) begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        logic [3:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check32(t, {28'b0, ctoErrOut}, {28'b0, e});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1 check32("R2 reset out", {28'b0, ctoErrOut}, 32'h0);
    for (int i = 0; i < 4; i++) readChk(2'(i), 12'h1d8, 32'h0, "R2 reset ctl");
    for (int i = 0; i < 4; i++) readChk(2'(i), 12'h1d4, 32'h00A10003, "R1 header");

    // R3 basic injection on port 0
    step(1, 0, 12'h1d8, 32'h4, 4'h0, "R3 pulse");
    step(0, 0, 12'h000, 32'h0, 4'h0, "R3 one cycle");
    step(0, 0, 12'h000, 32'h0, 4'h0, "R3 idle");
    readChk(0, 12'h1d8, 32'h4, "R2 readback");
    // R4 rewrite of 1, then clear and re-arm
    step(1, 0, 12'h1d8, 32'h4, 4'h0, "R4 rewrite");
    step(1, 0, 12'h1d8, 32'h4, 4'h0, "R4 rewrite2");
    step(1, 0, 12'h1d8, 32'h0, 4'h0, "R4 clear");
    step(1, 0, 12'h1d8, 32'h4, 4'h0, "R4 rearm");
    step(0, 0, 12'h000, 32'h0, 4'h0, "R4 idle");
    // R5 disable in same write
    step(1, 1, 12'h1d8, 32'h5, 4'h0, "R5 disabled");
    step(0, 1, 12'h000, 32'h0, 4'h0, "R5 idle");
    readChk(1, 12'h1d8, 32'h5, "R5 stored");
    step(1, 1, 12'h1d8, 32'h1, 4'h0, "R5 clear");
    step(1, 1, 12'h1d8, 32'h4, 4'h0, "R5 enabled pulse");
    step(0, 1, 12'h000, 32'h0, 4'h0, "R5 idle2");
    // R6 scratch bit
    step(1, 2, 12'h1d8, 32'h2, 4'h0, "R6 scratch");
    step(0, 2, 12'h000, 32'h0, 4'h0, "R6 idle");
    readChk(2, 12'h1d8, 32'h2, "R6 readback");
    // R2 reserved bits dropped
    step(1, 3, 12'h1d8, 32'hFFFF_FFF8, 4'h0, "R2 reserved write");
    step(0, 3, 12'h000, 32'h0, 4'h0, "R2 idle");
    readChk(3, 12'h1d8, 32'h0, "R2 reserved read");
    // R7 back-to-back ports
    step(1, 3, 12'h1d8, 32'h4, 4'h0, "R7 port3");
    step(1, 2, 12'h1d8, 32'h6, 4'h0, "R7 port2");
    step(0, 0, 12'h000, 32'h0, 4'h0, "R7 idle");
    readChk(0, 12'h1d8, 32'h4, "R7 port0 untouched");
    readChk(3, 12'h1d8, 32'h4, "R7 port3 stored");
    // R8 other offsets and header writes
    step(1, 1, 12'h1dc, 32'h4, 4'h0, "R8 stray write");
    step(1, 1, 12'h1d4, 32'h0, 4'h0, "R8 header write");
    step(0, 1, 12'h000, 32'h0, 4'h0, "R8 idle");
    readChk(1, 12'h1d8, 32'h4, "R8 ctl unchanged");
    readChk(1, 12'h1d4, 32'h00A10003, "R1 header after write");
    readChk(1, 12'h1dc, 32'h0, "R8 stray read");
    readChk(2, 12'h000, 32'h0, "R8 zero offset read");
    // R9 merge with real errors
    step(0, 0, 12'h000, 32'h0, 4'hA, "R9 real only");
    step(1, 0, 12'h1d8, 32'h0, 4'h5, "R9 clear");
    step(1, 0, 12'h1d8, 32'h4, 4'hA, "R9 merged");
    step(0, 0, 12'h000, 32'h0, 4'h0, "R9 idle");
    step(0, 0, 12'h000, 32'h0, 4'h0, "R9 idle2");

    repeat (3) @(posedge clk);
    running = 1'b0;
    #1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule